// File: doc/BRIEF.md
# Braking Resistor Thermal Limiter

This block estimates the temperature of a braking resistor from the power dumped into it. It keeps a first-order energy accumulator that rises towards the applied braking power with an exponential profile. The accumulator is scaled so that full scale is the hottest the resistor may run. The level is reported as a whole-number percentage of full scale. Once the level reaches full scale, the block responds in one of two ways.

In trip mode the block raises a thermal trip flag. The flag stays set until a clear pulse arrives. In inhibit mode it never trips. Instead it drops the brake-enable gate and holds it low until the level has cooled below 95% of full scale. This lets several resistors on a shared DC bus pass braking load to one another. While the gate is low, the power that reaches the accumulator is treated as zero, so the estimate cools.

Top module: `brk_therm_limiter`

## Requirements
- R1: After reset, `level_pct` is 0, `brake_en` is 1 and `trip` is 0.
- R2: On every clock with `tick` high, the accumulator becomes acc + floor((P_eff − acc) / 2^K), clamped to the range [0, FS]. `level_pct` shows floor(acc·100/FS). With the defaults K=3 and FS=10000.
- R3: While `tick` is low, the accumulator and `level_pct` hold their values.
- R4: The accumulator never exceeds FS. An input power above FS drives the level to exactly 100.
- R5: With `mode_inhibit`=0, an accumulator at or above FS sets `trip` on the next clock. `trip` then stays set until it is cleared.
- R6: A `trip_clr` pulse clears `trip` on the next clock only when the accumulator is below FS. If the limit is met in that same cycle, the set wins. Clearing leaves the accumulator unchanged.
- R7: With `mode_inhibit`=1, an accumulator at or above FS drives `brake_en` low on the next clock, and `trip` never rises.
- R8: While `brake_en` is low, the effective power P_eff is 0, so each tick cools the accumulator. Otherwise P_eff is `pwr_in`.
- R9: In inhibit mode, `brake_en` returns high on the clock after the accumulator is seen below floor(FS·95/100) (9500 by default). At or above that value it stays low.
- R10: With `mode_inhibit`=0, `brake_en` is high on the clock after the mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample enable for the accumulator |
| pwr_in | input | PW (16) | Braking power sample, same scale as FS |
| mode_inhibit | input | 1 | 0 = trip at full scale, 1 = brake inhibit with hysteresis |
| trip_clr | input | 1 | Synchronous clear of the latched trip |
| level_pct | output | 7 | Accumulator level in percent of full scale |
| brake_en | output | 1 | Gate enable for the braking transistor |
| trip | output | 1 | Latched thermal trip |

## Verification
A trip clear and a limit hit can land in the same cycle. To provoke this, the bench saturates the accumulator in trip mode and then pulses `trip_clr` while the level still reads 100. It judges the result by `trip` staying high. A later clear, issued after ticks with zero power have cooled the level, must drop `trip` and leave `level_pct` unchanged. A mode switch to trip mode while the gate is inhibited and the level is full is also checked. It must raise `brake_en` and `trip` on the same clock.

// File: rtl/brk_therm_pkg.sv
package brk_therm_pkg;
  typedef enum logic {
    MODE_TRIP    = 1'b0,
    MODE_INHIBIT = 1'b1
  } brk_mode_e;
endpackage

// File: rtl/brk_heat_acc.sv
module brk_heat_acc #(
  parameter int PW = 16,
  parameter int FS = 10000,
  parameter int K  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] pwr_eff,
  output logic [PW-1:0] acc_o
);
  localparam int SW = PW + 2;
  localparam logic [PW-1:0] FS_V = PW'(FS);

  function automatic logic [PW-1:0] heat_step(input logic [PW-1:0] a,
                                              input logic [PW-1:0] p);
    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] nxt;
    diff = $signed({2'b00, p}) - $signed({2'b00, a});
    nxt  = $signed({2'b00, a}) + (diff >>> K);
    if (nxt < 0)
      return '0;
    else if (nxt > $signed({2'b00, FS_V}))
      return FS_V;
    else
      return nxt[PW-1:0];
  endfunction

  logic [PW-1:0] acc_q;
  logic [PW-1:0] acc_step;

  assign acc_step = heat_step(acc_q, pwr_eff);

  always_ff @(posedge clk) begin
    if (!rst_n)
      acc_q <= '0;
    else if (tick)
      acc_q <= acc_step;
  end

  assign acc_o = acc_q;

  // R4
  acc_le_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= FS_V);

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_q));
endmodule

// File: rtl/brk_limit_ctrl.sv
module brk_limit_ctrl
  import brk_therm_pkg::*;
#(
  parameter int PW = 16,
  parameter int FS = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] acc,
  input  brk_mode_e     mode,
  input  logic          trip_clr,
  output logic          brake_en,
  output logic          trip
);
  localparam logic [PW-1:0] HI_V = PW'(FS);
  localparam logic [PW-1:0] LO_V = PW'((FS * 95) / 100);

  logic at_full;
  logic below_lo;
  logic trip_set;
  logic inhib_hit;

  assign at_full   = (acc >= HI_V);
  assign below_lo  = (acc < LO_V);
  assign trip_set  = at_full && (mode == MODE_TRIP);
  assign inhib_hit = at_full && (mode == MODE_INHIBIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip     <= 1'b0;
      brake_en <= 1'b1;
    end else begin
      trip <= (trip && !trip_clr) || trip_set;
      if (mode == MODE_TRIP)
        brake_en <= 1'b1;
      else if (inhib_hit)
        brake_en <= 1'b0;
      else if (below_lo)
        brake_en <= 1'b1;
    end
  end

  // R5
  trip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> $past(at_full && (mode == MODE_TRIP)));

  // R6
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !trip_clr) |=> trip);

  // R7
  inhib_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhib_hit |=> !brake_en);

  // R7
  brake_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brake_en) |-> $past(inhib_hit));

  // R9
  brake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brake_en) |-> $past(below_lo || (mode == MODE_TRIP)));
endmodule

// File: rtl/brk_therm_limiter.sv
module brk_therm_limiter
  import brk_therm_pkg::*;
#(
  parameter int PW = 16,
  parameter int FS = 10000,
  parameter int K  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] pwr_in,
  input  logic          mode_inhibit,
  input  logic          trip_clr,
  output logic [6:0]    level_pct,
  output logic          brake_en,
  output logic          trip
);
  localparam int MW = PW + 7;

  function automatic logic [6:0] to_pct(input logic [PW-1:0] a);
    logic [MW-1:0] m;
    m = {7'd0, a} * MW'(100);
    m = m / MW'(FS);
    return m[6:0];
  endfunction

  logic [PW-1:0] acc;
  logic [PW-1:0] pwr_eff;
  brk_mode_e     mode;

  assign mode    = brk_mode_e'(mode_inhibit);
  assign pwr_eff = brake_en ? pwr_in : '0;

  brk_heat_acc #(.PW(PW), .FS(FS), .K(K)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pwr_eff (pwr_eff),
    .acc_o   (acc)
  );

  brk_limit_ctrl #(.PW(PW), .FS(FS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .mode     (mode),
    .trip_clr (trip_clr),
    .brake_en (brake_en),
    .trip     (trip)
  );

  assign level_pct = to_pct(acc);

  // R8
  cool_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !brake_en) |=> (acc <= $past(acc)));
endmodule

// File: tb/brk_therm_limiter_tb.sv
module brk_therm_limiter_tb;
  localparam int PW = 16;
  localparam int FS = 10000;
  localparam int K  = 3;
  localparam int LO = (FS * 95) / 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [PW-1:0] pwr_in = '0;
  logic          mode_inhibit = 1'b0;
  logic          trip_clr = 1'b0;
  logic [6:0]    level_pct;
  logic          brake_en;
  logic          trip;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_acc = 0;
  bit m_be = 1'b1;
  bit m_trip = 1'b0;

  always #10 clk = ~clk;

  brk_therm_limiter #(.PW(PW), .FS(FS), .K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_in(pwr_in),
    .mode_inhibit(mode_inhibit), .trip_clr(trip_clr),
    .level_pct(level_pct), .brake_en(brake_en), .trip(trip)
  );

  typedef struct packed {
    logic        mode;
    logic [15:0] pwr;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 16'd4000,  8'd12},
    '{1'b0, 16'd0,     8'd8},
    '{1'b1, 16'd30000, 8'd20},
    '{1'b1, 16'd9000,  8'd10},
    '{1'b0, 16'd9800,  8'd15},
    '{1'b1, 16'd0,     8'd10}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_pct(input int a);
    return (a * 100) / FS;
  endfunction

  function automatic void model_flags(input bit clr);
    m_trip = (m_trip && !clr) || (m_acc >= FS && !mode_inhibit);
    if (!mode_inhibit) m_be = 1'b1;
    else if (m_acc >= FS) m_be = 1'b0;
    else if (m_acc < LO) m_be = 1'b1;
  endfunction

  function automatic void model_tick();
    int p;
    int d;
    p = m_be ? int'(pwr_in) : 0;
    d = p - m_acc;
    m_acc = m_acc + (d >>> K);
    if (m_acc < 0) m_acc = 0;
    if (m_acc > FS) m_acc = FS;
  endfunction

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(posedge clk);
    @(negedge clk) tick = 1'b0;
    model_tick();
    @(posedge clk);
    model_flags(1'b0);
    @(negedge clk);
    check("R2 level", int'(level_pct), exp_pct(m_acc));
    check("R9 brake_en", int'(brake_en), int'(m_be));
    check("R5 trip", int'(trip), int'(m_trip));
  endtask

  task automatic set_mode(input bit md, input int p);
    @(negedge clk);
    mode_inhibit = md;
    pwr_in = PW'(p);
    @(posedge clk);
    model_flags(1'b0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 level", int'(level_pct), 0);
    check("R1 brake_en", int'(brake_en), 1);
    check("R1 trip", int'(trip), 0);

    foreach (VEC[i]) begin
      set_mode(VEC[i].mode, int'(VEC[i].pwr));
      for (int t = 0; t < int'(VEC[i].n); t++) do_tick();
    end

    // R3: no tick, level holds
    set_mode(1'b0, 5000);
    held = int'(level_pct);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R3 hold", int'(level_pct), held);

    // R4, R5: saturate and trip
    set_mode(1'b0, 65535);
    for (int t = 0; t < 10; t++) do_tick();
    check("R4 level max", int'(level_pct), 100);
    check("R5 trip set", int'(trip), 1);

    // R6: clear while at full, set wins
    @(negedge clk) trip_clr = 1'b1;
    @(posedge clk);
    @(negedge clk) trip_clr = 1'b0;
    check("R6 clear at full ignored", int'(trip), 1);

    // R6: cool then clear
    set_mode(1'b0, 0);
    do_tick();
    do_tick();
    check("R6 level before clear", int'(level_pct), 76);
    @(negedge clk) trip_clr = 1'b1;
    @(posedge clk);
    model_flags(1'b1);
    @(negedge clk) trip_clr = 1'b0;
    check("R6 trip cleared", int'(trip), 0);
    check("R6 level unchanged", int'(level_pct), 76);

    // R7, R8, R9: inhibit cycle
    set_mode(1'b1, 65535);
    do_tick();
    check("R7 brake_en low", int'(brake_en), 0);
    check("R7 no trip", int'(trip), 0);
    do_tick();
    check("R8 cooled level", int'(level_pct), 87);
    check("R9 restored", int'(brake_en), 1);
    do_tick();
    check("R7 brake_en low again", int'(brake_en), 0);

    // R10: switch to trip mode while inhibited at full
    @(negedge clk) mode_inhibit = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 brake_en restored", int'(brake_en), 1);
    check("R5 trip on mode switch", int'(trip), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule